// File: doc/BRIEF.md
# RGMII Transmit Double-Data-Rate Encoder

This block takes a byte-wide transmit stream (one data byte, a valid flag and a fault flag per clock) and drives it onto a narrow set of output pins. In reduced mode, four data lines and one control line are driven on both clock edges. In wide mode, the same pins carry the low half of the byte and the plain valid flag at single data rate. The transmit clock is forwarded with the data, so a PHY can capture each half-cycle against that clock. The caller supplies the byte clock for the chosen line rate: 125 MHz for 1 Gbps, 25 MHz for 100 Mbps, and 2.5 MHz for 10 Mbps.

Each output bit is modelled as a double-data-rate cell. A rising-edge register and a falling-edge register feed a mux that the clock level selects. There is one register of latency. A byte presented before rising edge k appears in the high phase after edge k. Its second half appears in the following low phase. Mode and rate are taken from their inputs only while the valid flag is low. This means a frame in progress keeps the configuration it started with.

Top module: `rgmii_tx_enc`

## Requirements
- R1: In reduced mode at gigabit rate (`rate_sel[1]`=1), `pin_dat` carries byte bits [3:0] during the clock high phase and bits [7:4] during the low phase.
- R2: In reduced mode, `pin_ctl` equals the byte's valid flag during the clock high phase.
- R3: In reduced mode, `pin_ctl` equals valid XOR fault during the clock low phase, so idle gives 0/0, good data gives 1/1 and a flagged error gives 1/0.
- R4: In reduced mode at 10 Mbps (`rate_sel`=00) or 100 Mbps (`rate_sel`=01), `pin_dat` carries byte bits [3:0] in both phases.
- R5: In wide mode (`sel_reduced`=0), `pin_dat` carries byte bits [3:0] and `pin_ctl` carries the valid flag in both phases. The fault flag has no effect on the pins.
- R6: `sel_reduced` and `rate_sel` are captured only on rising edges where `tx_valid` is 0. While `tx_valid` stays 1, a change on them has no effect on the encoding.
- R7: While `rst_n` is low, `pin_dat`, `pin_ctl` and `fwd_clk` are all 0. After reset the data and control pins stay 0 until a byte is presented.
- R8: After the first rising edge out of reset, `fwd_clk` is 1 in each clock high phase and 0 in each low phase.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock at the line rate (125 / 25 / 2.5 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_byte | input | 8 | Transmit data byte |
| tx_valid | input | 1 | Byte is part of a frame |
| tx_fault | input | 1 | Byte carries a transmit error |
| sel_reduced | input | 1 | 1 = reduced DDR pins, 0 = wide single-rate pins |
| rate_sel | input | 2 | 00 = 10 Mbps, 01 = 100 Mbps, 1x = 1000 Mbps |
| fwd_clk | output | 1 | Forwarded transmit clock |
| pin_dat | output | 4 | Shared data lines |
| pin_ctl | output | 1 | Shared control line |

## Verification
Constrained random bytes go through frames of random length under every pairing of mode and rate. Each half-phase of the pins is compared with a model: this distinguishes the gigabit nibble split from the repeated nibble of the slow rates, and both of these from the single-rate wide mode. Fault flags are scattered over both idle and active bytes. This separates the XOR encoding on the falling-edge control value from a plain copy of valid. Directed cases change mode and rate in the middle of a frame and check during and after reset, which shows whether configuration is held across a frame and whether the pins start low.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;

  typedef struct packed {
    logic       reduced;
    logic [1:0] rate;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{reduced: 1'b0, rate: 2'b00};

  function automatic logic rate_is_gig(input logic [1:0] rate);
    return rate[1];
  endfunction

  // Nibble placed on the pins while the clock is high.
  function automatic logic [3:0] nib_high_phase(input logic [7:0] b);
    return b[3:0];
  endfunction

  // Nibble placed on the pins while the clock is low.
  function automatic logic [3:0] nib_low_phase(input logic [7:0] b, input tx_cfg_t c);
    if (c.reduced && rate_is_gig(c.rate)) return b[7:4];
    return b[3:0];
  endfunction

  // Control value for the low phase.
  function automatic logic ctl_low_phase(input logic en, input logic er, input tx_cfg_t c);
    if (c.reduced) return en ^ er;
    return en;
  endfunction

endpackage

// File: rtl/rgmii_ddr_cell.sv
module rgmii_ddr_cell #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_rise,
  input  logic [W-1:0] d_fall,
  output logic [W-1:0] q_rise,
  output logic [W-1:0] q_fall,
  output logic [W-1:0] q
);
  logic [W-1:0] fall_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rise    <= '0;
      fall_pend <= '0;
    end else begin
      q_rise    <= d_rise;
      fall_pend <= d_fall;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_fall <= '0;
    else        q_fall <= fall_pend;
  end

  assign q = clk ? q_rise : q_fall;
endmodule

// File: rtl/rgmii_cfg_hold.sv
module rgmii_cfg_hold
  import rgmii_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    busy,
  input  tx_cfg_t cfg_in,
  output tx_cfg_t cfg_q,
  output tx_cfg_t cfg_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= CFG_RESET;
    else if (!busy) cfg_q <= cfg_in;
  end

  // Idle bytes use the live inputs; frame bytes use the held copy.
  assign cfg_act = busy ? cfg_q : cfg_in;
endmodule

// File: rtl/rgmii_lane_map.sv
module rgmii_lane_map
  import rgmii_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int NW = BYTE_W / 2
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              en,
  input  logic              er,
  input  tx_cfg_t           cfg,
  output logic [NW:0]       rise_vec,
  output logic [NW:0]       fall_vec
);
  always_comb begin
    rise_vec = {en, nib_high_phase(byte_in)};
    fall_vec = {ctl_low_phase(en, er, cfg), nib_low_phase(byte_in, cfg)};
  end
endmodule

// File: rtl/rgmii_tx_enc.sv
module rgmii_tx_enc
  import rgmii_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  input  logic              tx_fault,
  input  logic              sel_reduced,
  input  logic [1:0]        rate_sel,
  output logic              fwd_clk,
  output logic [BYTE_W/2-1:0] pin_dat,
  output logic              pin_ctl
);
  localparam int NW    = BYTE_W / 2;
  localparam int LANES = NW + 1;

  tx_cfg_t cfg_in, cfg_q, cfg_act;
  logic [NW:0] rise_vec, fall_vec, lane_q, lane_rq, lane_fq;

  // Named events for the checker.
  logic          act_reduced, act_gig, held_reduced;
  logic [NW-1:0] dat_rise_q, dat_fall_q;
  logic          ctl_rise_q, ctl_fall_q;
  logic          clk_rise_q, clk_fall_q;

  assign cfg_in = '{reduced: sel_reduced, rate: rate_sel};

  rgmii_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(tx_valid),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .cfg_act(cfg_act)
  );

  rgmii_lane_map #(.BYTE_W(BYTE_W)) u_map (
    .byte_in(tx_byte), .en(tx_valid), .er(tx_fault), .cfg(cfg_act),
    .rise_vec(rise_vec), .fall_vec(fall_vec)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rgmii_ddr_cell #(.W(1)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .d_rise(rise_vec[g]), .d_fall(fall_vec[g]),
      .q_rise(lane_rq[g]), .q_fall(lane_fq[g]), .q(lane_q[g])
    );
  end

  rgmii_ddr_cell #(.W(1)) u_clk_cell (
    .clk(clk), .rst_n(rst_n),
    .d_rise(1'b1), .d_fall(1'b0),
    .q_rise(clk_rise_q), .q_fall(clk_fall_q), .q(fwd_clk)
  );

  assign pin_dat      = lane_q[NW-1:0];
  assign pin_ctl      = lane_q[NW];
  assign dat_rise_q   = lane_rq[NW-1:0];
  assign dat_fall_q   = lane_fq[NW-1:0];
  assign ctl_rise_q   = lane_rq[NW];
  assign ctl_fall_q   = lane_fq[NW];
  assign act_reduced  = cfg_act.reduced;
  assign act_gig      = rate_is_gig(cfg_act.rate);
  assign held_reduced = cfg_q.reduced;
endmodule

// File: rtl/rgmii_tx_enc_chk.sv
module rgmii_tx_enc_chk #(
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_fault,
  input logic          act_reduced,
  input logic          act_gig,
  input logic          held_reduced,
  input logic [NW-1:0] dat_rise_q,
  input logic [NW-1:0] dat_fall_q,
  input logic          ctl_rise_q,
  input logic          ctl_fall_q,
  input logic [NW-1:0] pin_dat,
  input logic          pin_ctl,
  input logic          fwd_clk
);
  p_ctl_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> ctl_rise_q);

  p_ctl_fall_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_valid) && $past(tx_fault) && $past(act_reduced)) |-> !ctl_fall_q);

  p_slow_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(act_reduced) && !$past(act_gig)) |-> (dat_fall_q == dat_rise_q));

  p_wide_sdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(act_reduced)) |-> (dat_fall_q == dat_rise_q && ctl_fall_q == ctl_rise_q));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_valid)) |-> $stable(held_reduced));

  p_reset_low_r7: assert property (@(posedge clk)
    !rst_n |-> (pin_dat == '0 && !pin_ctl && !fwd_clk));
endmodule

bind rgmii_tx_enc rgmii_tx_enc_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_fault(tx_fault),
  .act_reduced(act_reduced), .act_gig(act_gig), .held_reduced(held_reduced),
  .dat_rise_q(dat_rise_q), .dat_fall_q(dat_fall_q),
  .ctl_rise_q(ctl_rise_q), .ctl_fall_q(ctl_fall_q),
  .pin_dat(pin_dat), .pin_ctl(pin_ctl), .fwd_clk(fwd_clk)
);

// File: tb/rgmii_tx_enc_bench.sv
`timescale 1ns/1ps
module rgmii_tx_enc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_valid = 1'b0, tx_fault = 1'b0, sel_reduced = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       fwd_clk, pin_ctl;
  logic [3:0] pin_dat;

  int checks = 0, errors = 0;
  bit done = 0;
  logic       m_red = 1'b0;
  logic [1:0] m_rate = 2'b00;

  always #10 clk = ~clk;

  rgmii_tx_enc u_rgmii_tx_enc (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_fault(tx_fault), .sel_reduced(sel_reduced), .rate_sel(rate_sel),
    .fwd_clk(fwd_clk), .pin_dat(pin_dat), .pin_ctl(pin_ctl)
  );

  function automatic logic [3:0] want_dat(logic [7:0] b, bit low_phase, logic red, logic [1:0] rt);
    if (low_phase && red && (rt == 2'b10 || rt == 2'b11)) return b >> 4;
    return b & 8'h0f;
  endfunction

  function automatic logic want_ctl(logic en, logic er, bit low_phase, logic red);
    if (!low_phase || !red) return en;
    return (en && !er) || (!en && er);
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one byte (called just after a falling edge), then check both phases.
  task automatic send(logic [7:0] b, logic en, logic er, logic red, logic [1:0] rt);
    logic       u_red;
    logic [1:0] u_rt;
    string      dtag, ctag_hi, ctag_lo;
    tx_byte = b; tx_valid = en; tx_fault = er; sel_reduced = red; rate_sel = rt;
    if (en) begin u_red = m_red; u_rt = m_rate; end
    else begin u_red = red; u_rt = rt; m_red = red; m_rate = rt; end
    if (!u_red) begin dtag = "R5"; ctag_hi = "R5"; ctag_lo = "R5"; end
    else begin
      dtag = u_rt[1] ? "R1" : "R4";
      ctag_hi = "R2"; ctag_lo = "R3";
    end
    @(posedge clk); #5;
    chk(dtag, pin_dat, want_dat(b, 0, u_red, u_rt));
    chk(ctag_hi, {3'b0, pin_ctl}, {3'b0, want_ctl(en, er, 0, u_red)});
    chk("R8", {3'b0, fwd_clk}, 4'd1);
    @(negedge clk); #5;
    chk(dtag, pin_dat, want_dat(b, 1, u_red, u_rt));
    chk(ctag_lo, {3'b0, pin_ctl}, {3'b0, want_ctl(en, er, 1, u_red)});
    chk("R8", {3'b0, fwd_clk}, 4'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tx_byte = 8'hff; tx_fault = 1'b1; sel_reduced = 1'b1; rate_sel = 2'b10;
    repeat (3) begin
      @(negedge clk); #5;
      // R7: pins low in both phases during reset
      chk("R7", {pin_dat[3:1], pin_dat[0] | pin_ctl | fwd_clk}, 4'd0);
      @(posedge clk); #5;
      chk("R7", {pin_dat[3:1], pin_dat[0] | pin_ctl | fwd_clk}, 4'd0);
    end
    tx_byte = '0; tx_fault = 1'b0; sel_reduced = 1'b0; rate_sel = 2'b00;
    @(negedge clk); #5; rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R7", {pin_dat[3:1], pin_dat[0] | pin_ctl}, 4'd0);
    chk("R8", {3'b0, fwd_clk}, 4'd1);
    @(negedge clk); #5;
    chk("R7", {pin_dat[3:1], pin_dat[0] | pin_ctl}, 4'd0);

    // Directed: gigabit nibble split, error code, idle
    send(8'h00, 0, 0, 1, 2'b10);
    send(8'ha5, 1, 0, 1, 2'b10);   // R1, R2, R3 good data
    send(8'h3c, 1, 1, 1, 2'b10);   // R3 error 1/0
    send(8'hf0, 0, 1, 1, 2'b10);   // R3 idle with fault
    // R6: mid-frame switch to wide 10M must be ignored
    send(8'h5a, 1, 0, 0, 2'b00);
    send(8'h96, 1, 0, 0, 2'b00);
    send(8'h00, 0, 0, 0, 2'b00);   // takes effect now
    send(8'he7, 1, 1, 1, 2'b10);   // R6: still wide mode, fault ignored (R5)
    send(8'h00, 0, 0, 1, 2'b01);
    send(8'hc3, 1, 0, 1, 2'b10);   // R4: 100M held despite gig request

    // Constrained random frames
    for (int f = 0; f < 60; f++) begin
      logic       red = 1'($urandom_range(0, 1));
      logic [1:0] rt  = 2'($urandom_range(0, 3));
      int         len = $urandom_range(1, 12);
      send(8'($urandom), 0, 1'($urandom_range(0, 3) == 0), red, rt);
      for (int i = 0; i < len; i++)
        send(8'($urandom), 1, 1'($urandom_range(0, 7) == 0),
             1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
    end
    send(8'h00, 0, 0, 0, 2'b00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule